// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between program memory and the decode stage of a wide-issue core. It takes in fetch packets of eight 32-bit instruction words, 256 bits in all, and breaks each one into execute packets. An execute packet is a run of consecutive words that issue together. The length of each run comes from a chaining flag in the least significant bit of every word. Each clock, one execute packet goes out on eight output slots together with a per-slot valid mask.

A valid/ready handshake pulls fetch packets in, and the block accepts a new one only after it has issued every execute packet of the one it holds. A stall input freezes dispatch. The block does not decode opcodes or map words to functional units. It only finds group boundaries, orders issue and applies back-pressure to the fetch side.

Top module: `exec_packet_dispatcher`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), issueValid is 0, issueMask is 0, every slot is zero and fetchReady is 1 until a fetch packet is accepted.
- R2: An execute packet starts at the first word not yet issued and takes in following words for as long as the current word has bit 0 equal to 1. A word with bit 0 equal to 0 is the last word of its execute packet.
- R3: Bit 0 of the last word of a fetch packet (word 7) is ignored, and that word always closes the final execute packet. An execute packet never takes words from two fetch packets, so a fully chained packet issues as a single group of eight.
- R4: Fetch word i occupies fetchData[32*i+31 : 32*i]. The issued group is compacted: slot k (issueSlots[32*k+31 : 32*k]) carries the k-th word of the group, issueMask bits 0..n-1 are 1 for a group of n words, and every other slot and mask bit is zero.
- R5: While a fetch packet is held and stall is 0, issueValid is 1 and exactly one execute packet is consumed at each rising edge.
- R6: While stall is 1, issueValid and issueMask are 0 and nothing is consumed. The same group is presented again once stall returns to 0.
- R7: fetchReady is 1 only when no word of the held packet remains to be issued. A packet is accepted at an edge where fetchValid and fetchReady are both 1. fetchValid and fetchData have no effect at any other time.
- R8: Once a packet has been accepted, its first group is presented in the next cycle, provided stall is 0. After the edge that consumes the last group, fetchReady is 1 in the next cycle.
- R9: A packet whose words all have bit 0 equal to 0 takes eight consecutive issue cycles, each issuing a single-word group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 1 | Program memory offers a fetch packet |
| fetchReady | output | 1 | Block will take a fetch packet at this edge |
| fetchData | input | 256 | Fetch packet, word i in bits 32*i+31..32*i |
| stall | input | 1 | Holds dispatch while high |
| issueValid | output | 1 | An execute packet is presented and will be consumed at this edge |
| issueMask | output | 8 | Per-slot valid bits of the presented group, contiguous from slot 0 |
| issueSlots | output | 256 | Compacted instruction words of the group, slot k in bits 32*k+31..32*k |

## Verification
The bench uses the default parameters: eight slots of 32-bit words. These values cover both extremes. A fetch packet can form a single group of eight, or eight single-word groups, and the ignored chaining bit on word 7 sits at the real boundary. Alongside the directed cases, random chain patterns, stall bursts and fetchValid offers made while a packet is still pending are compared cycle by cycle against a behavioural queue model. The pending offers show that the block ignores data it must not accept.

// File: rtl/epd_pkg.sv
package epd_pkg;
  // Strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic load;     // capture a new fetch packet, restart at word 0
    logic advance;  // consume the presented execute packet
  } epdStrobe_t;
endpackage

// File: rtl/epd_boundary.sv
module epd_boundary #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] chainBits,
  input  logic [IDX_W-1:0]     startIdx,
  output logic [IDX_W-1:0]     endIdx
);
  // First word at or after startIdx that closes a group; the last word always closes.
  always_comb begin
    logic found;
    found  = 1'b0;
    endIdx = IDX_W'(NUM_SLOTS - 1);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && (IDX_W'(i) >= startIdx) &&
          (!chainBits[i] || (i == NUM_SLOTS - 1))) begin
        endIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/epd_ctrl.sv
module epd_ctrl
  import epd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fetchValid,
  input  logic       stall,
  input  logic       lastGroup,
  output logic       fetchReady,
  output logic       issueValid,
  output epdStrobe_t strobe
);
  logic loaded;

  assign fetchReady     = !loaded;
  assign issueValid     = loaded && !stall;
  assign strobe.load    = fetchValid && !loaded;
  assign strobe.advance = loaded && !stall;

  always_ff @(posedge clk) begin
    if (rst)                                 loaded <= 1'b0;
    else if (strobe.load)                    loaded <= 1'b1;
    else if (strobe.advance && lastGroup)    loaded <= 1'b0;
  end

  // R8: an accepted packet is presented next cycle unless stalled
  p_accept_presents_r8: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && fetchReady) |=> (issueValid || stall));

  // R8: consuming the final group frees the fetch side
  p_last_frees_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    (issueValid && lastGroup) |=> fetchReady);

  // R6: a stalled cycle leaves the packet pending
  p_stall_keeps_pending_r6: assert property (@(posedge clk) disable iff (rst)
    (stall && !fetchReady) |=> !fetchReady);
endmodule

// File: rtl/epd_datapath.sv
module epd_datapath
  import epd_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int PKT_W    = NUM_SLOTS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  epdStrobe_t           strobe,
  input  logic [PKT_W-1:0]     fetchData,
  input  logic                 issueValid,
  output logic [PKT_W-1:0]     issueSlots,
  output logic [NUM_SLOTS-1:0] issueMask,
  output logic                 lastGroup
);
  logic [WORD_W-1:0]    words [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] chainBits;
  logic [IDX_W-1:0]     startIdx;
  logic [IDX_W-1:0]     endIdx;
  logic [IDX_W-1:0]     span;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chain
    assign chainBits[i] = words[i][0];
  end

  epd_boundary #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) uBoundary (
    .chainBits (chainBits),
    .startIdx  (startIdx),
    .endIdx    (endIdx)
  );

  assign lastGroup = (endIdx == IDX_W'(NUM_SLOTS - 1));
  assign span      = endIdx - startIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      startIdx <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) words[i] <= '0;
    end else if (strobe.load) begin
      startIdx <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) words[i] <= fetchData[i*WORD_W +: WORD_W];
    end else if (strobe.advance) begin
      startIdx <= lastGroup ? '0 : endIdx + IDX_W'(1);
    end
  end

  // Compaction: slot k takes word startIdx+k when it lies inside the group
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [IDX_W-1:0] sel;
    logic             inGroup;
    assign sel          = startIdx + IDX_W'(k);
    assign inGroup      = issueValid && (IDX_W'(k) <= span);
    assign issueMask[k] = inGroup;
    assign issueSlots[k*WORD_W +: WORD_W] = inGroup ? words[sel] : '0;

    // R4: slots outside the group carry zero
    p_idle_slot_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !issueMask[k] |-> (issueSlots[k*WORD_W +: WORD_W] == '0));

    if (k < NUM_SLOTS - 1) begin : g_chainchk
      // R2: every word followed by another group member has its chain bit set
      p_member_chained_r2: assert property (@(posedge clk) disable iff (rst)
        issueMask[k+1] |-> issueSlots[k*WORD_W]);
    end
  end

  // R4: mask is a contiguous run starting at slot 0
  p_mask_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> (issueMask[0] &&
                    ((issueMask & (issueMask + NUM_SLOTS'(1))) == '0)));

  // R6: no consumption while nothing is issued and nothing is loaded
  p_index_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!issueValid && !strobe.load) |=> $stable(startIdx));
endmodule

// File: rtl/exec_packet_dispatcher.sv
module exec_packet_dispatcher
  import epd_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int WORD_W    = 32,
  localparam int PKT_W    = NUM_SLOTS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetchValid,
  output logic                 fetchReady,
  input  logic [PKT_W-1:0]     fetchData,
  input  logic                 stall,
  output logic                 issueValid,
  output logic [NUM_SLOTS-1:0] issueMask,
  output logic [PKT_W-1:0]     issueSlots
);
  epdStrobe_t strobe;
  logic       lastGroup;

  epd_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .fetchValid (fetchValid),
    .stall      (stall),
    .lastGroup  (lastGroup),
    .fetchReady (fetchReady),
    .issueValid (issueValid),
    .strobe     (strobe)
  );

  epd_datapath #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)) uData (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .fetchData  (fetchData),
    .issueValid (issueValid),
    .issueSlots (issueSlots),
    .issueMask  (issueMask),
    .lastGroup  (lastGroup)
  );

  // R6: stall blocks issue at the ports
  p_stall_blocks_issue_r6: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!issueValid && issueMask == '0));

  // R7: fetch side and issue side are never both active
  p_ready_only_idle_r7: assert property (@(posedge clk) disable iff (rst)
    fetchReady |-> !issueValid);
endmodule

// File: tb/exec_packet_dispatcher_test.sv
module exec_packet_dispatcher_test;
  localparam int N = 8;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchValid = 1'b0;
  logic fetchReady;
  logic [N*W-1:0] fetchData = '0;
  logic stall = 1'b0;
  logic issueValid;
  logic [N-1:0] issueMask;
  logic [N*W-1:0] issueSlots;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit mLoaded = 0;
  logic [W-1:0] mWords[$];
  int mStart = 0;

  always #2 clk = ~clk;

  exec_packet_dispatcher uut (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .fetchData(fetchData), .stall(stall), .issueValid(issueValid),
    .issueMask(issueMask), .issueSlots(issueSlots)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [N*W-1:0] d, input bit st);
    logic [N*W-1:0] expSlots;
    logic [N-1:0]   expMask;
    bit expValid;
    int e;
    @(negedge clk);
    fetchValid = fv; fetchData = d; stall = st;
    #1;
    expValid = mLoaded && !st;
    expSlots = '0;
    expMask  = '0;
    e = mStart;
    if (mLoaded) while (e < N-1 && mWords[e][0]) e++;
    if (expValid) begin
      for (int j = mStart; j <= e; j++) begin
        expSlots[(j-mStart)*W +: W] = mWords[j];
        expMask[j-mStart] = 1'b1;
      end
    end
    check(fetchReady == !mLoaded, "R7", "fetchReady", N*W'(fetchReady), N*W'(!mLoaded));
    check(issueValid == expValid, st ? "R6" : "R5", "issueValid",
          N*W'(issueValid), N*W'(expValid));
    check(issueMask == expMask, "R2", "issueMask", N*W'(issueMask), N*W'(expMask));
    check(issueSlots == expSlots, "R4", "issueSlots", issueSlots, expSlots);
    // reference update for the coming edge
    if (!mLoaded && fv) begin
      mWords.delete();
      for (int j = 0; j < N; j++) mWords.push_back(d[j*W +: W]);
      mLoaded = 1; mStart = 0;
    end else if (mLoaded && !st) begin
      if (e == N-1) mLoaded = 0;
      else mStart = e + 1;
    end
  endtask

  function automatic logic [N*W-1:0] mkPacket(input logic [N-1:0] chain, input int seed);
    logic [N*W-1:0] p;
    for (int j = 0; j < N; j++)
      p[j*W +: W] = {W'(32'h1000_0000 + seed*256 + j*2)} | W'(chain[j]) | W'(j << 8);
    return p;
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [N*W-1:0] pk;
    // reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(issueValid == 0 && issueMask == 0 && issueSlots == 0, "R1", "idle outputs after reset",
          issueSlots, '0);
    check(fetchReady == 1, "R1", "fetchReady after reset", N*W'(fetchReady), 1);
    step(0, '0, 0);

    // R9: all groups of one word
    step(1, mkPacket(8'h00, 1), 0);
    n = 0;
    for (int c = 0; c < 20; c++) begin
      step(0, '0, 0);
      if (issueValid) n++; else break;
    end
    check(n == 8, "R9", "single-word group count", N*W'(n), 8);

    // R3: fully chained including word 7, R8 timing
    step(1, mkPacket(8'hFF, 2), 0);
    step(0, '0, 0);
    check(issueMask == 8'hFF, "R3", "one group of eight", N*W'(issueMask), 8'hFF);
    step(0, '0, 0);
    check(fetchReady == 1, "R8", "ready after last group", N*W'(fetchReady), 1);

    // R6 stall mid packet, R7 offers ignored while pending; groups 3,1,4
    pk = mkPacket(8'b0111_0011, 3);
    step(1, pk, 1);
    step(1, mkPacket(8'hAA, 9), 1);
    check(issueValid == 0 && issueMask == 0, "R6", "stalled output", N*W'(issueMask), 0);
    step(1, mkPacket(8'h55, 9), 0);
    check(issueMask == 8'h07 && issueSlots[W-1:0] == pk[W-1:0], "R8", "first group after accept",
          N*W'(issueMask), 8'h07);
    step(1, mkPacket(8'h0F, 9), 1);
    step(1, mkPacket(8'h0F, 9), 0);
    check(issueMask == 8'h01 && issueSlots[W-1:0] == pk[3*W +: W], "R6", "same group after stall",
          issueSlots, {224'h0, pk[3*W +: W]});
    step(0, '0, 0);
    check(issueMask == 8'h0F && issueSlots[4*W-1:0] == pk[N*W-1:4*W], "R4", "compacted tail group",
          issueSlots, {128'h0, pk[N*W-1:4*W]});
    step(0, '0, 0);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N*W-1:0] r;
      for (int j = 0; j < N; j++) r[j*W +: W] = $urandom();
      step(($urandom % 4) != 0, r, ($urandom % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule